// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a synthesizable model of a single-port, 32-bit wide synchronous SRAM with a parameterised number of words. It serves a processor-style burst bus. Every control and data input is captured on the rising clock edge except the output enable, which acts combinationally. An address-load edge takes a new external address and starts a read there. The edges that follow continue a burst: an active-low advance input steps a 2-bit counter in the low address bits, and a wait leaves the address where it is. On these continuation edges the block writes when a write is requested and reads otherwise.

Writes are masked per byte lane. A global write stores the whole word, whatever the lane controls say. Read data comes back through a register one edge after the address is used. The bidirectional data bus is split into a write-data input, a read-data output and a data-output-enable flag.

A two-state controller holds the select status. `ST_DESEL` is the reset state and ignores all accesses. `ST_BURST` performs accesses. The named transitions are LOAD_SEL (any state to `ST_BURST`, when a load edge sees the depth-expansion enables asserted) and LOAD_DESEL (any state to `ST_DESEL`, when a load edge sees them deasserted). There are also two self-loops on non-load edges, ADVANCE and WAIT, which change only the address.

Top module: `burst_sram`

## Requirements
- R1: An edge with `adsp_n_i` = 0 and `ce1_n_i` = 0 is a load edge. It takes `addr_i` as the access address and performs a read there, never a write. The word read appears on `rdata_o` after that edge.
- R2: On a load edge the block becomes selected only if `ce2_n_i` = 0 and `ce3_i` = 1. Otherwise it becomes deselected. While deselected, no write takes place and `dq_oe_o` stays 0 until the next selecting load. On edges that are not load edges, `ce2_n_i`, `ce3_i` and `ce1_n_i` have no effect.
- R3: On a non-load edge with `adv_n_i` = 0, address bits [1:0] step by +1 modulo 4 before the access, and the upper bits are kept. A burst therefore wraps inside its aligned group of four words.
- R4: On a non-load edge with `adv_n_i` = 1, the access uses the same address as the previous edge.
- R5: On a selected non-load edge with `bwe_n_i` = 0 and `gw_n_i` = 1, each lane whose `bw_n_i` bit is 0 is written: bit 0 covers data[7:0], bit 1 covers [15:8], bit 2 covers [23:16] and bit 3 covers [31:24]. The other lanes keep their contents.
- R6: With `bwe_n_i` = 1 and `gw_n_i` = 1, the `bw_n_i` bits have no effect. The edge is a read.
- R7: A selected non-load edge with `gw_n_i` = 0 writes all 32 bits, whatever `bwe_n_i` and `bw_n_i` are.
- R8: `dq_oe_o` is 0 whenever a write is requested, that is when `gw_n_i` = 0, or when `bwe_n_i` = 0 and any `bw_n_i` bit is 0.
- R9: `oe_n_i` = 1 forces `dq_oe_o` to 0 combinationally, with no clock edge involved.
- R10: `dq_oe_o` is 1 exactly when the previous edge was a selected read, `oe_n_i` = 0 and no write is requested. In that case `rdata_o` holds the word at the address of that edge.
- R11: After reset the block is deselected, the burst address is 0 and `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External word address |
| adsp_n_i | input | 1 | Active-low address-load strobe |
| ce1_n_i | input | 1 | Active-low primary chip enable |
| ce2_n_i | input | 1 | Active-low expansion enable |
| ce3_i | input | 1 | Active-high expansion enable |
| adv_n_i | input | 1 | Active-low burst advance |
| gw_n_i | input | 1 | Active-low global write |
| bwe_n_i | input | 1 | Active-low byte-write enable |
| bw_n_i | input | 4 | Active-low byte-lane strobes |
| oe_n_i | input | 1 | Active-low asynchronous output enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| dq_oe_o | output | 1 | Data output driver enable |

## Verification
Two functions can meet in one cycle: a write request arriving on the edge right after a read, and the read data that edge has just made valid. The write request must then pull `dq_oe_o` low combinationally, while `rdata_o` still holds the earlier word. The same clash occurs when burst advance and a write share an edge, because the counter must step before the lane mask is applied. Directed sequences place a write straight after a load and apply advance together with writes. The constrained-random phase mixes the two freely. Each cycle, the output enable and read data are compared against a bench-side model of memory, address and select state.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int BCNT_W = 2;

    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_BURST = 1'b1
    } bst_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adsp_n_i,
    input  logic              ce1_n_i,
    input  logic              ce2_n_i,
    input  logic              ce3_i,
    input  logic              adv_n_i,
    input  logic              wr_req_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              rd_en_o,
    output logic              wr_en_o
);
    localparam int UP_W = ADDR_W - BCNT_W;

    bst_e              state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              load_edge;
    logic              ce_ok;

    assign load_edge = !adsp_n_i && !ce1_n_i;
    assign ce_ok     = !ce2_n_i && ce3_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= acc_addr_o;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        acc_addr_o = addr_q;
        rd_en_o    = 1'b0;
        wr_en_o    = 1'b0;
        if (load_edge) begin
            acc_addr_o = addr_i;
            state_d    = ce_ok ? ST_BURST : ST_DESEL;
            rd_en_o    = ce_ok;
        end else begin
            if (!adv_n_i) begin
                acc_addr_o = {addr_q[ADDR_W-1 -: UP_W], addr_q[BCNT_W-1:0] + 2'd1};
            end
            unique case (state_q)
                ST_DESEL: begin
                    rd_en_o = 1'b0;
                    wr_en_o = 1'b0;
                end
                ST_BURST: begin
                    rd_en_o = !wr_req_i;
                    wr_en_o = wr_req_i;
                end
                default: ;
            endcase
        end
    end

    assign addr_q_o = addr_q;
endmodule

// File: rtl/burst_sram_wmask.sv
module burst_sram_wmask
    import burst_sram_pkg::*;
(
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bw_n_i,
    output logic [LANES-1:0] lane_we_o,
    output logic             wr_req_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we_o[l] = !gw_n_i || (!bwe_n_i && !bw_n_i[l]);
    end

    assign wr_req_o = |lane_we_o;
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  we_i,
    input  logic              rd_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we_i[l]) begin
                mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
            end
            if (rd_i) begin
                rd_q <= mem[addr_i];
            end
        end

        assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adsp_n_i,
    input  logic              ce1_n_i,
    input  logic              ce2_n_i,
    input  logic              ce3_i,
    input  logic              adv_n_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [3:0]        bw_n_i,
    input  logic              oe_n_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              dq_oe_o
);
    logic [LANES-1:0]  lane_we;
    logic              wr_req;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_en;
    logic              wr_en;
    logic              rvalid_q;

    burst_sram_wmask u_wmask (
        .gw_n_i   (gw_n_i),
        .bwe_n_i  (bwe_n_i),
        .bw_n_i   (bw_n_i),
        .lane_we_o(lane_we),
        .wr_req_o (wr_req)
    );

    burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .adsp_n_i  (adsp_n_i),
        .ce1_n_i   (ce1_n_i),
        .ce2_n_i   (ce2_n_i),
        .ce3_i     (ce3_i),
        .adv_n_i   (adv_n_i),
        .wr_req_i  (wr_req),
        .acc_addr_o(acc_addr),
        .addr_q_o  (addr_q),
        .rd_en_o   (rd_en),
        .wr_en_o   (wr_en)
    );

    burst_sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .addr_i (acc_addr),
        .we_i   (lane_we & {LANES{wr_en}}),
        .rd_i   (rd_en),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid_q <= 1'b0;
        else        rvalid_q <= rd_en;
    end

    // asynchronous output gating
    assign dq_oe_o = rvalid_q && !oe_n_i && !wr_req;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adsp_n_i,
    input logic              ce1_n_i,
    input logic              ce2_n_i,
    input logic              ce3_i,
    input logic              adv_n_i,
    input logic              gw_n_i,
    input logic              bwe_n_i,
    input logic [3:0]        bw_n_i,
    input logic              oe_n_i,
    input logic              dq_oe_o,
    input logic [ADDR_W-1:0] addr_q
);
    logic load_e, sel_ok, wreq;
    assign load_e = !adsp_n_i && !ce1_n_i;
    assign sel_ok = !ce2_n_i && ce3_i;
    assign wreq   = !gw_n_i || (!bwe_n_i && (bw_n_i != 4'hF));

    assert_wr_blocks_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wreq |-> !dq_oe_o);

    assert_oe_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o);

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_e && !sel_ok) |=> !dq_oe_o);

    assert_load_reads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_e && sel_ok) |=> (dq_oe_o == (!oe_n_i && !wreq)));

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_e && adv_n_i) |=> $stable(addr_q));

    assert_adv_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_e && !adv_n_i) |=>
            ((addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)) &&
             (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adsp_n_i(adsp_n_i),
    .ce1_n_i (ce1_n_i),
    .ce2_n_i (ce2_n_i),
    .ce3_i   (ce3_i),
    .adv_n_i (adv_n_i),
    .gw_n_i  (gw_n_i),
    .bwe_n_i (bwe_n_i),
    .bw_n_i  (bw_n_i),
    .oe_n_i  (oe_n_i),
    .dq_oe_o (dq_oe_o),
    .addr_q  (addr_q)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b0, ce3 = 1'b1;
    logic          adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [3:0]    bw_n = 4'hF;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          dq_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .adsp_n_i(adsp_n),
        .ce1_n_i(ce1_n), .ce2_n_i(ce2_n), .ce3_i(ce3), .adv_n_i(adv_n),
        .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n),
        .wdata_i(wdata), .rdata_o(rdata), .dq_oe_o(dq_oe)
    );

    // bench model of the requirements
    logic [31:0]   mm [DEPTH];
    logic [AW-1:0] m_addr = '0;
    logic          m_sel = 1'b0, m_rvalid = 1'b0;
    logic [31:0]   m_rdata = '0;
    bit            chk_en = 1'b0;
    int            n_chk = 0, n_fail = 0;

    function automatic logic wr_req_f(logic g, logic b, logic [3:0] s);
        return !g || (!b && (s != 4'hF));
    endfunction

    function automatic logic [3:0] lanes_f(logic g, logic b, logic [3:0] s);
        return !g ? 4'hF : (!b ? ~s : 4'h0);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [3:0] we;
        if (!adsp_n && !ce1_n) begin
            m_addr = addr;
            m_sel  = !ce2_n && ce3;
            m_rvalid = m_sel;
            if (m_sel) m_rdata = mm[m_addr];
        end else begin
            if (!adv_n) m_addr = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
            if (!m_sel) m_rvalid = 1'b0;
            else if (wr_req_f(gw_n, bwe_n, bw_n)) begin
                we = lanes_f(gw_n, bwe_n, bw_n);
                for (int l = 0; l < 4; l++)
                    if (we[l]) mm[m_addr][l*8 +: 8] = wdata[l*8 +: 8];
                m_rvalid = 1'b0;
            end else begin
                m_rvalid = 1'b1;
                m_rdata  = mm[m_addr];
            end
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic adsp, input logic c1,
                        input logic c2, input logic c3, input logic adv,
                        input logic g, input logic b, input logic [3:0] s,
                        input logic oe, input logic [31:0] wd, input string tag);
        logic exp_oe;
        @(negedge clk);
        addr = a; adsp_n = adsp; ce1_n = c1; ce2_n = c2; ce3 = c3; adv_n = adv;
        gw_n = g; bwe_n = b; bw_n = s; oe_n = oe; wdata = wd;
        #1;
        if (chk_en) begin
            exp_oe = m_rvalid && !oe && !wr_req_f(g, b, s);
            check(dq_oe == exp_oe, {tag, " dq_oe"}, 32'(dq_oe), 32'(exp_oe));
            if (m_rvalid)
                check(rdata == m_rdata, {tag, " rdata"}, rdata, m_rdata);
        end
        @(posedge clk);
        model_edge();
    endtask

    task automatic ld(input logic [AW-1:0] a, input string tag);
        step(a, 0, 0, 0, 1, 1, 1, 1, 4'hF, 0, 32'h0, tag);
    endtask

    task automatic rd(input logic adv, input string tag);
        step('0, 1, 1, 0, 1, adv, 1, 1, 4'hF, 0, 32'h0, tag);
    endtask

    task automatic wr(input logic adv, input logic g, input logic b, input logic [3:0] s,
                      input logic [31:0] wd, input string tag);
        step('0, 1, 1, 0, 1, adv, g, b, s, 0, wd, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(dq_oe == 1'b0, "R11 reset dq_oe", 32'(dq_oe), 32'h0);

        // fill memory with a known image (checks off)
        for (int g = 0; g < DEPTH/4; g++) begin
            ld(AW'(g*4), "init");
            for (int k = 0; k < 4; k++)
                wr(0, 0, 1, 4'hF, $urandom(), "init");
        end
        rd(1, "init");
        chk_en = 1'b1;

        // R1: load is a read; write controls on the load edge are ignored
        step(8'h10, 0, 0, 0, 1, 1, 0, 0, 4'h0, 0, 32'hDEADBEEF, "R1 load");
        rd(1, "R1 load data");
        rd(1, "R1 load data");
        // write right after a read: oe must drop (R8)
        ld(8'h20, "R8 setup");
        wr(1, 0, 1, 4'hF, 32'h11223344, "R8 write-after-read");
        wr(1, 1, 0, 4'hE, 32'h55667788, "R8 byte write");
        rd(1, "R7 global write result");
        // R3: burst wraps in aligned group
        ld(8'h0E, "R3 load");
        rd(0, "R3 advance");
        rd(0, "R3 wrap");
        rd(0, "R3 wrap");
        rd(0, "R3 back");
        // R4: wait keeps address
        rd(1, "R4 wait");
        rd(1, "R4 wait");
        // R5: each lane alone
        ld(8'h30, "R5 load");
        for (int l = 0; l < 4; l++) begin
            wr(1, 1, 0, ~(4'h1 << l), 32'hA0B1C2D3 + l, "R5 lane write");
            rd(1, "R5 lane read");
            rd(1, "R5 lane read");
        end
        // R6: strobes without byte-write enable are a read
        wr(1, 1, 1, 4'h0, 32'hFFFFFFFF, "R6 strobes ignored");
        rd(1, "R6 data kept");
        // R7: global write overrides bwe/strobes
        wr(0, 0, 1, 4'hF, 32'hCAFEF00D, "R7 gw");
        rd(1, "R7 read back");
        rd(1, "R7 read back");
        // R9: asynchronous output enable
        ld(8'h44, "R9 load");
        rd(1, "R9 read");
        @(negedge clk); oe_n = 1'b1; #1;
        check(dq_oe == 1'b0, "R9 oe high", 32'(dq_oe), 32'h0);
        #1; oe_n = 1'b0; #1;
        check(dq_oe == 1'b1, "R9 oe low", 32'(dq_oe), 32'h1);
        // R2: deselect blocks writes; enables ignored off load edges
        step(8'h50, 0, 0, 0, 0, 1, 1, 1, 4'hF, 0, 32'h0, "R2 desel load");
        wr(1, 0, 1, 4'hF, 32'h12345678, "R2 desel write");
        wr(0, 0, 1, 4'hF, 32'h87654321, "R2 desel write");
        rd(1, "R2 desel read");
        step(8'h50, 0, 0, 1, 1, 1, 1, 1, 4'hF, 0, 32'h0, "R2 ce2 desel");
        ld(8'h50, "R2 reselect");
        step('0, 1, 1, 1, 0, 0, 1, 1, 4'hF, 0, 32'h0, "R2 ce ignored");
        rd(1, "R2 ce ignored");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            step(AW'($urandom()), ($urandom_range(0, 4) != 0), ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 6) == 0), ($urandom_range(0, 6) != 0),
                 1'($urandom()), ($urandom_range(0, 9) != 0), ($urandom_range(0, 2) != 0),
                 4'($urandom()), ($urandom_range(0, 4) == 0), $urandom(), "R10 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule